// File: doc/BRIEF.md
# 32-bit Arithmetic-Logic Unit with Status Flags

This block is the purely combinational arithmetic-logic unit of a multicycle processor core. It receives two operand words, a three-bit function code and a separate carry input. It returns a result word and four status bits in the same cycle. The sequencer uses the status bits to decide branches.

The unit offers addition with carry, subtraction, four bitwise logic functions, and two less-than comparisons, one signed and one unsigned. Each comparison produces a whole word equal to 0 or 1. Subtraction is formed as A + ~B + 1 on the shared adder. Both comparisons reuse that difference.

Top module: `alu_core`

## Requirements
- R1: With op_i = 3'd0 (add), result_o equals a_i + b_i + carry_i modulo 2^32, and carry_o is bit 32 of that sum.
- R2: With op_i = 3'd1 (subtract), result_o equals a_i - b_i modulo 2^32 whatever carry_i is, and carry_o is 1 exactly when a_i >= b_i unsigned (no borrow).
- R3: For add and subtract, ovf_o is 1 exactly when the true signed result lies outside the range -2^31 to 2^31-1.
- R4: op_i = 3'd2, 3'd3, 3'd4 and 3'd5 give bitwise AND, OR, XOR and NOR of a_i and b_i.
- R5: For the logic functions and both comparisons (op_i from 3'd2 to 3'd7), carry_o and ovf_o are 0.
- R6: With op_i = 3'd6, result_o is 32'd1 when a_i < b_i as two's-complement signed values and 32'd0 otherwise, including when a_i - b_i overflows.
- R7: With op_i = 3'd7, result_o is 32'd1 when a_i < b_i as unsigned values and 32'd0 otherwise.
- R8: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R9: neg_o equals bit 31 of result_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Function code |
| carry_i | input | 1 | Carry into the adder for add |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Most significant result bit |
| carry_o | output | 1 | Adder carry out, 0 for non-arithmetic functions |
| ovf_o | output | 1 | Signed overflow, 0 for non-arithmetic functions |

## Verification
The bench builds the unit with its default width of 32. Its reference model computes each result in 64-bit integers, so the true carry out of bit 31 and the exact signed sum can be read directly, without a copy of the adder. With this width the directed vectors can use the corner cases at the sign boundary and the all-ones wrap: 0x7FFFFFFF + 1, 0x80000000 - 1, and 0xFFFFFFFF + 0 with carry in. They also cover a signed comparison whose difference overflows.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOR  = 3'd5,
    OP_SLT  = 3'd6,
    OP_SLTU = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  assign b_eff  = inv_b_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
  // operands agree in sign, sum disagrees
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_fn_e        fn_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_less.sv
module alu_less (
  input  logic diff_msb_i,
  input  logic diff_ovf_i,
  input  logic diff_cout_i,
  input  logic unsigned_i,
  output logic lt_o
);
  // signed: sign of difference corrected by overflow; unsigned: borrow
  assign lt_o = unsigned_i ? ~diff_cout_i : (diff_msb_i ^ diff_ovf_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_op_e          op;
  logic             use_sub;
  logic             is_arith;
  logic             cin_eff;
  logic [WIDTH-1:0] sum;
  logic             sum_cout;
  logic             sum_ovf;
  logic [WIDTH-1:0] lg_y;
  logic             lt;
  logic_fn_e        lg_fn;

  assign op       = alu_op_e'(op_i);
  assign use_sub  = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign cin_eff  = use_sub ? 1'b1 : carry_i;
  assign lg_fn    = logic_fn_e'(op_i[1:0] - 2'd2);

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .inv_b_i (use_sub),
    .cin_i   (cin_eff),
    .sum_o   (sum),
    .cout_o  (sum_cout),
    .ovf_o   (sum_ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (lg_fn),
    .y_o  (lg_y)
  );

  alu_less u_less (
    .diff_msb_i  (sum[MSB]),
    .diff_ovf_i  (sum_ovf),
    .diff_cout_i (sum_cout),
    .unsigned_i  (op == OP_SLTU),
    .lt_o        (lt)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:  result_o = sum;
      OP_SLT, OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, lt};
      default:         result_o = lg_y;
    endcase
  end

  assign zero_o  = ~|result_o;
  assign neg_o   = result_o[MSB];
  assign carry_o = is_arith & sum_cout;
  assign ovf_o   = is_arith & sum_ovf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             carry_o,
  input logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    if (op_i >= 3'd2)
      a_r5_quiet_flags: assert (!carry_o && !ovf_o)
        else $error("R5 flags raised for non-arithmetic function");
    if (op_i == 3'd1)
      a_r2_no_borrow: assert (carry_o == (a_i >= b_i))
        else $error("R2 carry does not match no-borrow");
    if (op_i == 3'd7)
      a_r7_unsigned_lt: assert (result_o == {{(WIDTH-1){1'b0}}, (a_i < b_i)})
        else $error("R7 unsigned compare wrong");
    if (op_i == 3'd6)
      a_r6_signed_lt: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("R6 signed compare wrong");
    if (op_i == 3'd0)
      a_r3_add_overflow: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
        else $error("R3 add overflow wrong");
    a_r8_zero_flag: assert (zero_o == (result_o == '0))
      else $error("R8 zero flag wrong");
    a_r9_neg_flag: assert (neg_o == result_o[MSB])
      else $error("R9 negative flag wrong");
    a_r1_carry_in_known: assert (!$isunknown(carry_i) || op_i != 3'd0)
      else $error("R1 carry input unknown on add");
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [2:0]  op_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        zero_o, neg_o, carry_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_core #(.WIDTH(32)) dut_i (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .carry_i(carry_i),
    .result_o(result_o), .zero_o(zero_o), .neg_o(neg_o),
    .carry_o(carry_o), .ovf_o(ovf_o)
  );

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd6: return "R6";
      3'd7: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check1(input string tag, input string what,
                        input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%h b=%h cin=%0d actual=%h expected=%h",
               tag, what, op_i, a_i, b_i, carry_i, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] op, input logic cin);
    longint ua, ub, us, sa, sb, ss;
    logic [31:0] e_res;
    logic e_c, e_v;
    @(posedge clk);
    a_i = a; b_i = b; op_i = op; carry_i = cin;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e_c = 1'b0; e_v = 1'b0;
    case (op)
      3'd0: begin
        us = ua + ub + longint'(cin);
        ss = sa + sb + longint'(cin);
        e_res = us[31:0];
        e_c = us[32];
        e_v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd1: begin
        ss = sa - sb;
        e_res = a - b;
        e_c = (ua >= ub);
        e_v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd2: e_res = a & b;
      3'd3: e_res = a | b;
      3'd4: e_res = a ^ b;
      3'd5: e_res = ~(a | b);
      3'd6: e_res = (sa < sb) ? 32'd1 : 32'd0;
      default: e_res = (ua < ub) ? 32'd1 : 32'd0;
    endcase
    @(negedge clk);
    check1(res_tag(op), "result", longint'(result_o), longint'(e_res));
    check1((op <= 3'd1) ? (op == 3'd0 ? "R1" : "R2") : "R5", "carry",
           longint'(carry_o), longint'(e_c));
    check1((op <= 3'd1) ? "R3" : "R5", "ovf", longint'(ovf_o), longint'(e_v));
    check1("R8", "zero", longint'(zero_o), longint'(e_res == 32'd0));
    check1("R9", "neg", longint'(neg_o), longint'(e_res[31]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero inputs, add -> zero result, zero flag (R1, R8)
    @(negedge clk);
    check1("R8", "reset zero", longint'(zero_o), 1);
    check1("R1", "reset result", longint'(result_o), 0);

    // R1: wrap, carry-in, plain
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd0, 1'b0);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 3'd0, 1'b1);
    apply(32'h0000_0010, 32'h0000_0020, 3'd0, 1'b1);
    // R3: positive and negative overflow on add
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 3'd0, 1'b0);
    // R2: carry_i ignored, borrow cases
    apply(32'h0000_0005, 32'h0000_0005, 3'd1, 1'b0);
    apply(32'h0000_0005, 32'h0000_0005, 3'd1, 1'b1);
    apply(32'h0000_0000, 32'h0000_0001, 3'd1, 1'b0);
    apply(32'h8000_0000, 32'h0000_0001, 3'd1, 1'b1);
    // R4, R5: logic with carry_i set
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd2, 1'b1);
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd3, 1'b1);
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd4, 1'b1);
    apply(32'h0000_0000, 32'h0000_0000, 3'd5, 1'b1);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 3'd5, 1'b0);
    // R6: signed compare including overflowing difference
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd6, 1'b0);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'd6, 1'b0);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd6, 1'b1);
    apply(32'h0000_0003, 32'h0000_0003, 3'd6, 1'b0);
    // R7: unsigned compare
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd7, 1'b0);
    apply(32'h0000_0001, 32'hFFFF_FFFF, 3'd7, 1'b1);
    apply(32'h0000_0000, 32'h0000_0000, 3'd7, 1'b0);

    for (int i = 0; i < 2400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = (i % 5 == 0) ? ra : $urandom();
      apply(ra, rb, 3'(i % 8), 1'($urandom() & 1));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule